// File: doc/BRIEF.md
# Flash Erase Command Sequencer

This block is the command front end of an on-chip flash array. It watches bus write cycles and recognises the multi-cycle erase commands: bulk erase, sector erase, erase suspend, erase resume and reset. A sector erase opens a collection window. Further sector confirm writes landing inside that window join a per-sector bit mask, and each one restarts the window. When the window runs out, the block starts an external erase engine on every collected sector at once.

While an operation is in flight, reads return a status byte instead of array data. That byte carries the busy bit, a toggling bit, a failure flag and a window flag. A sector erase can be suspended so that other sectors can be read. Reads aimed at a sector under erase are then flagged as not valid.

The erase engine, including its preprogramming of each byte to 00h before the erase to FFh, sits outside this block. So do the cell array and all erase physics. The block reaches the engine through a start/hold/abort and done/fail handshake. The window length and the suspend latency are parameters counted in clock cycles.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, a read with a sector select active returns the array data `arr_rdata` on `rd_data` with `rd_valid` high in the following cycle, and `eng_start`, `eng_hold` and `eng_mask` are all low.
- R2: Bulk erase is started by six writes with a sector select active: AAh to 555h, 55h to 2AAh, 80h to 555h, AAh to 555h, 55h to 2AAh, then 10h to 555h. In the cycle after the sixth write, `eng_start` pulses with `eng_bulk`=1 and `eng_mask` all ones. Status reads then show bit 7 = 0 and bit 3 = 1. Once `eng_done` arrives, reads return array data.
- R3: If any one of the six writes carries a wrong data value, the sequence is dropped. No engine start follows, and the next read returns array data.
- R4: A sector erase uses the same first five writes, then 30h with one select bit set (bit i = sector i). `eng_start` pulses exactly `TMO_CYC` cycles after the last 30h write that lands inside the window. `eng_mask` is then the OR of all selects collected in the window, and `eng_bulk` is 0.
- R5: Status bit 3 reads 0 while the collection window is open and 1 once the erase has started.
- R6: During the window, any write other than 30h or B0h drops the operation. No engine start follows, and reads return array data.
- R7: While an operation is busy, status bit 7 reads 0 and bit 6 flips on every consecutive status read.
- R8: A running sector erase ignores every write except B0h and F0h. A running bulk erase ignores every write, including F0h.
- R9: A B0h write during a sector erase raises `eng_hold` in the next cycle. Status reads continue for `SUSP_LAT` cycles. After that, reads of a sector in the erase mask return `rd_valid`=0 and `rd_data`=00h, while reads of other sectors return valid array data.
- R10: A B0h write inside the window also ends the window, so no engine start occurs while suspended. A later 30h write starts the engine at that point if it had not yet started. Otherwise it drops `eng_hold` without a new start, and toggling resumes.
- R11: While suspended, only 30h and F0h are acted on. F0h while suspended or running pulses `eng_abort` for one cycle, and the block returns to array reads.
- R12: An `eng_fail` pulse sets status bit 5 to 1. The block keeps returning status until an F0h write, after which reads return array data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W | Bus address |
| bus_wdata | input | 8 | Write data |
| sect_sel | input | NSECT | Per-sector select, one-hot |
| arr_rdata | input | 8 | Array data for the current address |
| rd_data | output | 8 | Read data, registered |
| rd_valid | output | 1 | Read data qualifier, one cycle after a read |
| eng_start | output | 1 | One-cycle engine start pulse |
| eng_bulk | output | 1 | Current operation is a bulk erase |
| eng_mask | output | NSECT | Sectors targeted by the erase |
| eng_hold | output | 1 | Engine must pause (suspend) |
| eng_abort | output | 1 | One-cycle engine abort pulse |
| eng_done | input | 1 | Engine finished successfully |
| eng_fail | input | 1 | Engine exceeded its erase cycle limit |

## Verification
A wrong control state shows up at the ports within one or two cycles. Either the next read returns status where array data was expected (or the reverse), or a select-gated `rd_valid` drops on the wrong sector. A window counter that is off by even one cycle moves the `eng_start` pulse, and the bench measures that pulse against the cycle of the last confirm write. A mask bit dropped or merged wrongly is visible on `eng_mask` in the very start cycle. Lost suspend or resume bookkeeping appears either as a second start pulse or as a missing one.

// File: rtl/fes_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the flash erase command sequencer.
// Assumes 8-bit data bus; status bit positions are fixed by bus convention.
package fes_pkg;

    typedef enum logic [3:0] {
        S_READ, S_U1, S_U2, S_SETUP, S_U4, S_U5,
        S_WIN, S_RUN, S_SPEND, S_SUSP, S_BULK, S_FAIL
    } fes_state_t;

    localparam logic [7:0] D_UNLK1  = 8'hAA;
    localparam logic [7:0] D_UNLK2  = 8'h55;
    localparam logic [7:0] D_SETUP  = 8'h80;
    localparam logic [7:0] D_BULK   = 8'h10;
    localparam logic [7:0] D_SECT   = 8'h30;
    localparam logic [7:0] D_SUSP   = 8'hB0;
    localparam logic [7:0] D_RESET  = 8'hF0;

    typedef struct packed {
        logic any;
        logic first;
        logic second;
        logic setup;
        logic bulk;
        logic sect;
        logic susp;
        logic rst;
    } fes_cmd_t;

endpackage

// File: rtl/fes_cmd_decode.sv
`timescale 1ns/1ps
// Classifies a bus write into the command tokens the sequencer understands.
// Assumes a write only counts while at least one sector select is active.
module fes_cmd_decode #(
    parameter int ADDR_W = 12,
    parameter int NSECT  = 4,
    parameter logic [ADDR_W-1:0] ADR_A = ADDR_W'(12'h555),
    parameter logic [ADDR_W-1:0] ADR_B = ADDR_W'(12'h2AA)
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic [NSECT-1:0]  sect_sel,
    output fes_pkg::fes_cmd_t cmd
);
    import fes_pkg::*;

    logic wr_ok;
    logic at_a;
    logic at_b;

    // qualify the write and the two unlock addresses
    always_comb begin
        wr_ok = bus_wr && (|sect_sel);
        at_a  = (bus_addr == ADR_A);
        at_b  = (bus_addr == ADR_B);
    end

    // decode data value and address into command tokens
    always_comb begin
        cmd        = '0;
        cmd.any    = wr_ok;
        cmd.first  = wr_ok && at_a && (bus_wdata == D_UNLK1);
        cmd.second = wr_ok && at_b && (bus_wdata == D_UNLK2);
        cmd.setup  = wr_ok && at_a && (bus_wdata == D_SETUP);
        cmd.bulk   = wr_ok && at_a && (bus_wdata == D_BULK);
        cmd.sect   = wr_ok && (bus_wdata == D_SECT);
        cmd.susp   = wr_ok && (bus_wdata == D_SUSP);
        cmd.rst    = wr_ok && (bus_wdata == D_RESET);
    end

endmodule

// File: rtl/fes_cycle_timer.sv
`timescale 1ns/1ps
// Counts clock cycles while enabled and flags the last cycle of a LIMIT-long span.
// Assumes LIMIT >= 1; load takes priority over counting.
module fes_cycle_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic done
);
    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    // cycle counter, cleared by load, advanced while run
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt <= '0;
        else if (load)      cnt <= '0;
        else if (run && cnt != LAST) cnt <= cnt + 1'b1;
    end

    // terminal flag for the final enabled cycle
    always_comb done = run && !load && (cnt == LAST);

endmodule

// File: rtl/fes_read_path.sv
`timescale 1ns/1ps
// Produces registered read data: a status byte while busy, array data otherwise,
// and a withheld qualifier for sectors parked under a suspended erase.
// Assumes status bit layout: 7 busy-low, 6 toggle, 5 fail, 3 window expired.
module fes_read_path (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_req,
    input  logic       status_mode,
    input  logic       dq3_val,
    input  logic       dq5_val,
    input  logic       hide,
    input  logic [7:0] arr_rdata,
    output logic [7:0] rd_data,
    output logic       rd_valid
);
    logic tog;

    // register the read result and flip the toggle bit per status read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
            tog      <= 1'b0;
        end else begin
            rd_valid <= rd_req && (status_mode || !hide);
            if (rd_req) begin
                if (status_mode) begin
                    rd_data <= {1'b0, tog, dq5_val, 1'b0, dq3_val, 3'b000};
                    tog     <= ~tog;
                end else if (hide) begin
                    rd_data <= 8'h00;
                end else begin
                    rd_data <= arr_rdata;
                end
            end
        end
    end

endmodule

// File: rtl/flash_erase_seq.sv
`timescale 1ns/1ps
// Command sequencer for flash erase: decodes unlock sequences, collects sector
// addresses inside a restartable window, drives the erase engine handshake,
// handles suspend/resume/reset and serves status or array reads.
// Assumes one-hot sector selects and an engine that honours hold and abort.
module flash_erase_seq #(
    parameter int ADDR_W   = 12,
    parameter int NSECT    = 4,
    parameter int TMO_CYC  = 20,
    parameter int SUSP_LAT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic [NSECT-1:0]  sect_sel,
    input  logic [7:0]        arr_rdata,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    output logic              eng_start,
    output logic              eng_bulk,
    output logic [NSECT-1:0]  eng_mask,
    output logic              eng_hold,
    output logic              eng_abort,
    input  logic              eng_done,
    input  logic              eng_fail
);
    import fes_pkg::*;

    fes_cmd_t        cmd;
    fes_state_t      st, st_n;
    logic [NSECT-1:0] mask_n;
    logic            started, started_n;
    logic            start_n, abort_n, bulk_n;
    logic            win_load, win_done, spend_done;
    logic            status_mode, dq3_val, dq5_val, hide;

    fes_cmd_decode #(
        .ADDR_W(ADDR_W), .NSECT(NSECT)
    ) dec_i (
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .sect_sel(sect_sel), .cmd(cmd)
    );

    fes_cycle_timer #(.LIMIT(TMO_CYC)) win_tmr_i (
        .clk(clk), .rst_n(rst_n), .load(win_load),
        .run(st == S_WIN), .done(win_done)
    );

    fes_cycle_timer #(.LIMIT(SUSP_LAT)) susp_tmr_i (
        .clk(clk), .rst_n(rst_n), .load(st != S_SPEND),
        .run(st == S_SPEND), .done(spend_done)
    );

    // next-state, mask and engine pulse decisions
    always_comb begin
        st_n      = st;
        mask_n    = eng_mask;
        started_n = started;
        bulk_n    = eng_bulk;
        start_n   = 1'b0;
        abort_n   = 1'b0;
        win_load  = 1'b0;
        case (st)
            S_READ:  if (cmd.any) st_n = cmd.first  ? S_U1    : S_READ;
            S_U1:    if (cmd.any) st_n = cmd.second ? S_U2    : S_READ;
            S_U2:    if (cmd.any) st_n = cmd.setup  ? S_SETUP : S_READ;
            S_SETUP: if (cmd.any) st_n = cmd.first  ? S_U4    : S_READ;
            S_U4:    if (cmd.any) st_n = cmd.second ? S_U5    : S_READ;
            S_U5: begin
                if (cmd.bulk) begin
                    st_n      = S_BULK;
                    mask_n    = '1;
                    bulk_n    = 1'b1;
                    start_n   = 1'b1;
                    started_n = 1'b1;
                end else if (cmd.sect) begin
                    st_n      = S_WIN;
                    mask_n    = sect_sel;
                    bulk_n    = 1'b0;
                    started_n = 1'b0;
                    win_load  = 1'b1;
                end else if (cmd.any) begin
                    st_n = S_READ;
                end
            end
            S_WIN: begin
                if (cmd.sect) begin
                    mask_n   = eng_mask | sect_sel;
                    win_load = 1'b1;
                end else if (cmd.susp) begin
                    st_n = S_SPEND;
                end else if (cmd.any) begin
                    st_n   = S_READ;
                    mask_n = '0;
                end else if (win_done) begin
                    st_n      = S_RUN;
                    start_n   = 1'b1;
                    started_n = 1'b1;
                end
            end
            S_RUN: begin
                if (cmd.susp) begin
                    st_n = S_SPEND;
                end else if (cmd.rst) begin
                    st_n    = S_READ;
                    mask_n  = '0;
                    abort_n = 1'b1;
                end else if (eng_fail) begin
                    st_n = S_FAIL;
                end else if (eng_done) begin
                    st_n   = S_READ;
                    mask_n = '0;
                end
            end
            S_SPEND: if (spend_done) st_n = S_SUSP;
            S_SUSP: begin
                if (cmd.sect) begin
                    st_n = S_RUN;
                    if (!started) begin
                        start_n   = 1'b1;
                        started_n = 1'b1;
                    end
                end else if (cmd.rst) begin
                    st_n    = S_READ;
                    mask_n  = '0;
                    abort_n = started;
                end
            end
            S_BULK: begin
                if (eng_fail) begin
                    st_n = S_FAIL;
                end else if (eng_done) begin
                    st_n   = S_READ;
                    mask_n = '0;
                    bulk_n = 1'b0;
                end
            end
            S_FAIL: begin
                if (cmd.rst) begin
                    st_n   = S_READ;
                    mask_n = '0;
                    bulk_n = 1'b0;
                end
            end
            default: st_n = S_READ;
        endcase
    end

    // state and engine handshake registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= S_READ;
            eng_mask  <= '0;
            eng_bulk  <= 1'b0;
            started   <= 1'b0;
            eng_start <= 1'b0;
            eng_abort <= 1'b0;
        end else begin
            st        <= st_n;
            eng_mask  <= mask_n;
            eng_bulk  <= bulk_n;
            started   <= started_n;
            eng_start <= start_n;
            eng_abort <= abort_n;
        end
    end

    // hold the engine while suspending or suspended
    always_comb eng_hold = (st == S_SPEND) || (st == S_SUSP);

    // status qualifiers for the read path
    always_comb begin
        status_mode = (st == S_WIN) || (st == S_RUN) || (st == S_SPEND) ||
                      (st == S_BULK) || (st == S_FAIL);
        dq3_val     = (st != S_WIN);
        dq5_val     = (st == S_FAIL);
        hide        = (st == S_SUSP) && (|(sect_sel & eng_mask));
    end

    fes_read_path rd_i (
        .clk(clk), .rst_n(rst_n), .rd_req(bus_rd && (|sect_sel)),
        .status_mode(status_mode), .dq3_val(dq3_val), .dq5_val(dq5_val),
        .hide(hide), .arr_rdata(arr_rdata),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

endmodule

// File: rtl/fes_chk.sv
`timescale 1ns/1ps
// Port-level protocol checks for the erase sequencer, attached by bind.
// Assumes synchronous active-low reset.
module fes_chk #(
    parameter int NSECT = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_rd,
    input logic             rd_valid,
    input logic             eng_start,
    input logic             eng_bulk,
    input logic [NSECT-1:0] eng_mask,
    input logic             eng_hold,
    input logic             eng_abort
);
    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!eng_start && !eng_hold && !eng_abort && eng_mask == '0)); // R1
    AST_VALID_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> $past(bus_rd)); // R1
    AST_BULK_ALL_SECT: assert property (@(posedge clk) disable iff (!rst_n) (eng_start && eng_bulk) |-> (&eng_mask)); // R2
    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n) eng_start |=> !eng_start); // R4
    AST_START_HAS_SECT: assert property (@(posedge clk) disable iff (!rst_n) eng_start |-> (eng_mask != '0)); // R4
    AST_NO_START_HELD: assert property (@(posedge clk) disable iff (!rst_n) eng_hold |-> !eng_start); // R10
    AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n) eng_abort |=> !eng_abort); // R11
    AST_ABORT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n) eng_abort |-> (!eng_hold && !eng_start)); // R11
endmodule

bind flash_erase_seq fes_chk #(.NSECT(NSECT)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .rd_valid(rd_valid),
    .eng_start(eng_start), .eng_bulk(eng_bulk), .eng_mask(eng_mask),
    .eng_hold(eng_hold), .eng_abort(eng_abort)
);

// File: tb/flash_erase_seq_tb.sv
`timescale 1ns/1ps
module flash_erase_seq_tb_top;
    localparam int ADDR_W = 12;
    localparam int NSECT  = 4;
    localparam int TMO    = 20;
    localparam int SLAT   = 3;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              bus_wr, bus_rd;
    logic [ADDR_W-1:0] bus_addr;
    logic [7:0]        bus_wdata;
    logic [NSECT-1:0]  sect_sel;
    logic [7:0]        arr_rdata;
    logic [7:0]        rd_data;
    logic              rd_valid, eng_start, eng_bulk, eng_hold, eng_abort;
    logic [NSECT-1:0]  eng_mask;
    logic              eng_done, eng_fail;

    int n_chk = 0, n_bad = 0, cyc = 0;
    int start_cnt = 0, start_cyc = 0, abort_cnt = 0;
    logic [NSECT-1:0] start_mask;
    logic start_bulk;

    always #2.5 clk = ~clk;

    flash_erase_seq #(.ADDR_W(ADDR_W), .NSECT(NSECT), .TMO_CYC(TMO), .SUSP_LAT(SLAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .sect_sel(sect_sel), .arr_rdata(arr_rdata),
        .rd_data(rd_data), .rd_valid(rd_valid), .eng_start(eng_start), .eng_bulk(eng_bulk),
        .eng_mask(eng_mask), .eng_hold(eng_hold), .eng_abort(eng_abort),
        .eng_done(eng_done), .eng_fail(eng_fail));

    function automatic logic [7:0] arr_f(input logic [ADDR_W-1:0] a, input logic [NSECT-1:0] s);
        return a[7:0] ^ {s, 4'h5};
    endfunction
    assign arr_rdata = arr_f(bus_addr, sect_sel);

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) begin
        if (eng_start) begin
            start_cnt  <= start_cnt + 1;
            start_cyc  <= cyc;
            start_mask <= eng_mask;
            start_bulk <= eng_bulk;
        end
        if (eng_abort) abort_cnt <= abort_cnt + 1;
    end

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    always @(posedge clk) if (cyc > 50000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected < 50000", cyc);
        summary();
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d, input logic [NSECT-1:0] s);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; sect_sel = s;
        @(negedge clk);
        bus_wr = 1'b0; sect_sel = '0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [NSECT-1:0] s,
                      output logic [7:0] d, output logic v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a; sect_sel = s;
        @(negedge clk);
        bus_rd = 1'b0; sect_sel = '0;
        d = rd_data; v = rd_valid;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_done(input bit fail);
        @(negedge clk);
        if (fail) eng_fail = 1'b1; else eng_done = 1'b1;
        @(negedge clk);
        eng_fail = 1'b0; eng_done = 1'b0;
    endtask

    // six-cycle sequence; bad_pos in 0..5 corrupts that cycle and stops there
    task automatic seq(input logic [7:0] last, input logic [NSECT-1:0] s, input int bad_pos);
        for (int i = 0; i < 6; i++) begin
            logic [ADDR_W-1:0] a;
            logic [7:0] d;
            case (i)
                0, 3: begin a = 12'h555; d = 8'hAA; end
                1, 4: begin a = 12'h2AA; d = 8'h55; end
                2:    begin a = 12'h555; d = 8'h80; end
                default: begin a = 12'h555; d = last; end
            endcase
            if (i == bad_pos) d = d ^ 8'h01;
            wr(a, d, s);
            if (i == bad_pos) return;
        end
    endtask

    task automatic chk_array(input logic [NSECT-1:0] s, input string tag);
        logic [7:0] d; logic v;
        rd(12'h0A3, s, d, v);
        chk(v === 1'b1, tag, {31'd0, v}, 32'd1);
        chk(d === arr_f(12'h0A3, s), tag, {24'd0, d}, {24'd0, arr_f(12'h0A3, s)});
    endtask

    initial begin
        logic [7:0] d, d2; logic v, v2;
        int wcyc, sc;
        rst_n = 1'b0; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
        sect_sel = '0; eng_done = 0; eng_fail = 0;
        idle(3); rst_n = 1'b1; idle(1);

        // R1 reset state
        chk(eng_start === 0 && eng_hold === 0 && eng_mask === '0, "R1 engine idle",
            {eng_start, eng_hold, 26'd0, eng_mask}, 0);
        chk_array(4'b0001, "R1 array read");

        // R2 bulk erase
        sc = start_cnt;
        seq(8'h10, 4'b0010, -1);
        chk(eng_start === 1 && eng_bulk === 1 && eng_mask === 4'hF, "R2 bulk start",
            {eng_start, eng_bulk, 26'd0, eng_mask}, 32'hC000000F);
        idle(1);
        chk(eng_start === 0, "R2 start one cycle", {31'd0, eng_start}, 0);
        rd(12'h0A3, 4'b0100, d, v);
        rd(12'h0A3, 4'b0100, d2, v2);
        chk(v && d[7] == 0 && d[3] == 1, "R2 bulk status", {24'd0, d}, 32'h08);
        chk(d[6] != d2[6] && d2[7] == 0, "R7 toggle bulk", {24'd0, d2}, {24'd0, d ^ 8'h40});
        wr(12'h555, 8'hF0, 4'b0001);
        rd(12'h0A3, 4'b0100, d, v);
        chk(v && d[7] == 0 && d[6] != d2[6], "R8 bulk ignores F0", {24'd0, d}, {24'd0, d2 ^ 8'h40});
        pulse_done(0);
        chk_array(4'b0100, "R2 after done");
        chk(start_cnt == sc + 1, "R2 one start", start_cnt, sc + 1);

        // R3 corrupt each cycle, both command kinds
        for (int k = 0; k < 2; k++)
            for (int p = 0; p < 6; p++) begin
                sc = start_cnt;
                seq(k ? 8'h30 : 8'h10, 4'b0001, p);
                idle(TMO + 3);
                chk(start_cnt == sc, "R3 no start", start_cnt, sc);
                chk_array(4'b0001, "R3 array after abort");
            end

        // R4/R5 each sector alone
        for (int s = 0; s < NSECT; s++) begin
            sc = start_cnt;
            seq(8'h30, 4'(1 << s), -1);
            wcyc = cyc;
            rd(12'h0A3, 4'b0001, d, v);
            chk(v && d[3] == 0 && d[7] == 0, "R5 window dq3 low", {24'd0, d}, 0);
            while (start_cnt == sc) idle(1);
            chk(start_cyc - wcyc == TMO, "R4 window length", start_cyc - wcyc, TMO);
            chk(start_mask == 4'(1 << s) && start_bulk == 0, "R4 mask single",
                {start_bulk, 27'd0, start_mask}, 1 << s);
            rd(12'h0A3, 4'b0001, d, v);
            chk(v && d[3] == 1, "R5 running dq3 high", {24'd0, d}, 32'h08);
            pulse_done(0);
        end

        // R4 restart by second sector
        sc = start_cnt;
        seq(8'h30, 4'b0001, -1);
        idle(5);
        wr(12'h777, 8'h30, 4'b0100);
        wcyc = cyc;
        while (start_cnt == sc) idle(1);
        chk(start_cyc - wcyc == TMO, "R4 window restart", start_cyc - wcyc, TMO);
        chk(start_mask == 4'b0101, "R4 mask merge", start_mask, 4'b0101);
        pulse_done(0);

        // R6 other command in window
        sc = start_cnt;
        seq(8'h30, 4'b0010, -1);
        idle(2);
        wr(12'h555, 8'h80, 4'b0010);
        idle(TMO + 3);
        chk(start_cnt == sc, "R6 window abort", start_cnt, sc);
        chk_array(4'b0010, "R6 array after abort");

        // R8/R9/R11 running, suspend, resume, reset
        sc = start_cnt;
        seq(8'h30, 4'b0010, -1);
        while (start_cnt == sc) idle(1);
        wr(12'h555, 8'hAA, 4'b0010);
        rd(12'h0A3, 4'b0010, d, v);
        chk(v && d[7] == 0, "R8 run ignores AA", {24'd0, d}, 0);
        wr(12'h123, 8'hB0, 4'b0010);
        chk(eng_hold === 1, "R9 hold after B0", {31'd0, eng_hold}, 1);
        rd(12'h0A3, 4'b0010, d, v);
        chk(v && d[7] == 0 && d[3] == 1, "R9 status during latency", {24'd0, d}, 32'h08);
        idle(SLAT + 2);
        rd(12'h0A3, 4'b0010, d, v);
        chk(v === 0 && d === 8'h00, "R9 suspended sector hidden", {23'd0, v, d}, 0);
        chk_array(4'b0100, "R9 other sector valid");
        wr(12'h555, 8'hAA, 4'b0100);
        rd(12'h0A3, 4'b0010, d, v);
        chk(v === 0, "R11 suspend ignores AA", {31'd0, v}, 0);
        wr(12'h000, 8'h30, 4'b0100);
        chk(eng_hold === 0, "R10 resume drops hold", {31'd0, eng_hold}, 0);
        chk(start_cnt == sc + 1, "R10 no second start", start_cnt, sc + 1);
        rd(12'h0A3, 4'b0001, d, v);
        rd(12'h0A3, 4'b0001, d2, v2);
        chk(v && v2 && d[6] != d2[6], "R7 toggle after resume", {24'd0, d2}, {24'd0, d ^ 8'h40});
        wr(12'h000, 8'hB0, 4'b0010);
        idle(SLAT + 2);
        sc = abort_cnt;
        wr(12'h000, 8'hF0, 4'b0001);
        chk(eng_abort === 1, "R11 abort pulse", {31'd0, eng_abort}, 1);
        idle(1);
        chk(eng_abort === 0 && abort_cnt == sc + 1, "R11 abort once", abort_cnt, sc + 1);
        chk_array(4'b0010, "R11 array after reset");

        // R11 reset while running
        sc = start_cnt;
        seq(8'h30, 4'b0001, -1);
        while (start_cnt == sc) idle(1);
        sc = abort_cnt;
        wr(12'h000, 8'hF0, 4'b0001);
        idle(1);
        chk(abort_cnt == sc + 1, "R11 run reset aborts", abort_cnt, sc + 1);
        chk_array(4'b0001, "R11 array after run reset");

        // R10 suspend inside window, R12 failure
        sc = start_cnt;
        seq(8'h30, 4'b1000, -1);
        idle(3);
        wr(12'h000, 8'hB0, 4'b1000);
        idle(TMO + 5);
        chk(start_cnt == sc, "R10 window ended by suspend", start_cnt, sc);
        wr(12'h000, 8'h30, 4'b0001);
        chk(eng_start === 1 && eng_mask === 4'b1000, "R10 resume starts",
            {eng_start, 27'd0, eng_mask}, 32'h80000008);
        pulse_done(1);
        rd(12'h0A3, 4'b0001, d, v);
        chk(v && d[5] == 1 && d[7] == 0, "R12 fail flag", {24'd0, d}, 32'h28);
        wr(12'h555, 8'hAA, 4'b0001);
        rd(12'h0A3, 4'b0001, d, v);
        chk(v && d[5] == 1, "R12 fail persists", {24'd0, d}, 32'h28);
        wr(12'h000, 8'hF0, 4'b0001);
        chk_array(4'b0001, "R12 array after reset");

        summary();
    end
endmodule